// File: doc/BRIEF.md
# PCM Time-Slot Interchanger

This block reorders the 8-bit voice samples of one framed PCM stream. Each frame holds a fixed number of slots, 24 or 32 depending on the line type. Each slot carries one 8-bit sample for one voice channel. Slot bytes arrive in parallel, one per clock. A strobe marks the first slot of each frame.

Every incoming frame is written into one half of a two-bank speech store while the frame before it is read out of the other half. So the reordered frame comes out exactly one frame later, plus one register stage. A per-slot connection table sets the new order. A simple host write port loads the table.

The table serves two addressing styles, chosen by a static input:
- In the first style, input is written in arrival order and each output slot picks the input slot it reads.
- In the second style, each input slot picks the output position it is stored at, and the output is read in order.

Every table entry also carries an idle/busy mark. Slots that carry no connection emit the all-ones idle byte.

Top module: `slot_interchanger`

## Requirements
- R1: During and after reset, `outByte` is 0xFF and `outValid` and `outStart` are 0. All connection entries start idle, so every output slot emits 0xFF until entries are programmed.
- R2: A cycle with `frameStart` high carries input slot 0. The following SLOTS-1 cycles carry slots 1 to SLOTS-1. Bytes presented after the last slot and before the next strobe are ignored.
- R3: Output slot k built from the frame whose strobe was sampled at one edge is presented after the edge that samples slot k of the next frame. `outValid` is high for all SLOTS output slots, and `outStart` is high only with output slot 0. The bank being written is never the bank being read.
- R4: With `modeRandWr`=0, entry k controls output slot k. If the entry is busy, output slot k carries the byte of input slot `sel`.
- R5: With `modeRandWr`=1, entry k controls input slot k. If the entry is busy, input slot k is placed at output slot `sel`. If the entry is idle, the byte is discarded.
- R6: The idle byte 0xFF is emitted in two cases. With `modeRandWr`=0, it is emitted for an output slot whose entry is idle. With `modeRandWr`=1, it is emitted for an output slot that no busy entry targets. When several busy inputs target one output, the highest-numbered input slot wins.
- R7: A host write (`cfgWe` high; entry index `cfgIdx`, `sel` value `cfgSel`, busy flag `cfgBusy`) goes into a staging copy of the table. The staging copy becomes active only at the edge that samples a strobe. A write on the strobe cycle itself applies from the frame after that one.
- R8: A host write whose `cfgIdx` or `cfgSel` (both 6 bits) is at or above SLOTS is ignored.
- R9: Outside an output frame, including gap cycles between frames, `outValid` is 0 and `outByte` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | High with slot 0 of an input frame |
| inByte | input | 8 | Input slot byte |
| modeRandWr | input | 1 | 0: ordered write, table-driven read; 1: table-driven write, ordered read |
| cfgWe | input | 1 | Table write enable |
| cfgIdx | input | 6 | Table entry index |
| cfgSel | input | 6 | Slot number stored in the entry |
| cfgBusy | input | 1 | 1 marks the entry busy, 0 idle |
| outByte | output | 8 | Output slot byte |
| outValid | output | 1 | High while an output slot is presented |
| outStart | output | 1 | High with output slot 0 |

## Verification
On every cycle, the assertions enforce four rules:
- The active table changes only on a strobe edge.
- Rejected host writes leave the staging table untouched.
- Write addresses stay inside the frame.
- The write and read banks differ, and gap cycles show the idle byte with `outValid` low.

Only the bench scenarios can show that a frame actually comes out in the programmed order. They also show that collisions in the table-driven-write style resolve to the last input, and that bytes in the gaps between frames leave the stored frame intact. Finally, they show that a table change made mid-frame first appears one frame later.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int MAX_SLOTS = 32;
  localparam int IDX_W = $clog2(MAX_SLOTS);
  localparam int PCM_W = 8;
  localparam logic [PCM_W-1:0] IDLE_BYTE = 8'hFF;

  // one connection-table entry
  typedef struct packed {
    logic             busy;
    logic [IDX_W-1:0] sel;
  } ctl_t;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic             live;
    logic             frameMark;
    logic             clrBank;
    logic             wrEn;
    logic             wrBank;
    logic [IDX_W-1:0] wrAddr;
    logic             rdBank;
    logic [IDX_W-1:0] rdAddr;
    logic             useFlag;
    logic             forceIdle;
  } strobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             modeRandWr,
  input  logic             cfgWe,
  input  logic [IDX_W:0]   cfgIdx,
  input  logic [IDX_W:0]   cfgSel,
  input  logic             cfgBusy,
  output strobe_t          st
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);
  localparam logic [IDX_W:0]   SLOT_LIM  = (IDX_W + 1)'(SLOTS);

  logic [IDX_W-1:0]  slotReg;
  logic              inFrame;
  logic              wrBankReg;
  ctl_t [SLOTS-1:0]  shadowMem;
  ctl_t [SLOTS-1:0]  activeMem;

  logic              live;
  logic [IDX_W-1:0]  curSlot;
  logic [IDX_W-1:0]  slotIdx;
  logic              curWb;
  ctl_t              ctlCur;
  logic              cfgOk;

  always_comb begin
    live    = frameStart || inFrame;
    curSlot = frameStart ? '0 : slotReg + 1'b1;
    slotIdx = live ? curSlot : '0;
    curWb   = frameStart ? ~wrBankReg : wrBankReg;
    ctlCur  = frameStart ? shadowMem[0] : activeMem[slotIdx];
    cfgOk   = cfgWe && (cfgIdx < SLOT_LIM) && (cfgSel < SLOT_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotReg   <= LAST_SLOT;
      inFrame   <= 1'b0;
      wrBankReg <= 1'b0;
      shadowMem <= '0;
      activeMem <= '0;
    end else begin
      if (live) slotReg <= curSlot;
      inFrame <= live && (curSlot != LAST_SLOT);
      if (frameStart) begin
        wrBankReg <= ~wrBankReg;
        activeMem <= shadowMem;
      end
      if (cfgOk) shadowMem[cfgIdx[IDX_W-1:0]] <= '{busy: cfgBusy, sel: cfgSel[IDX_W-1:0]};
    end
  end

  always_comb begin
    st           = '0;
    st.live      = live;
    st.frameMark = frameStart;
    st.clrBank   = frameStart;
    st.wrBank    = curWb;
    st.rdBank    = ~curWb;
    if (!modeRandWr) begin
      st.wrEn      = live;
      st.wrAddr    = slotIdx;
      st.rdAddr    = ctlCur.sel;
      st.useFlag   = 1'b0;
      st.forceIdle = !ctlCur.busy;
    end else begin
      st.wrEn      = live && ctlCur.busy;
      st.wrAddr    = ctlCur.sel;
      st.rdAddr    = slotIdx;
      st.useFlag   = 1'b1;
      st.forceIdle = 1'b0;
    end
  end

  // R7: active table only changes on a strobe edge
  a_r7_active_holds: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeMem));

  // R8: out-of-range host writes leave staging table alone
  a_r8_bad_cfg_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && ((cfgIdx >= SLOT_LIM) || (cfgSel >= SLOT_LIM))) |=> $stable(shadowMem));

  // R2: writes never leave the frame
  a_r2_wr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> (st.wrAddr <= LAST_SLOT));
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [PCM_W-1:0] inByte,
  output logic [PCM_W-1:0] outByte,
  output logic             outValid,
  output logic             outStart
);
  logic [PCM_W-1:0] mem  [2][SLOTS];
  logic [SLOTS-1:0] flag [2];
  logic [PCM_W-1:0] rdByte;
  logic             rdOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        flag[b] <= '0;
        for (int s = 0; s < SLOTS; s++) mem[b][s] <= '0;
      end
    end else begin
      for (int b = 0; b < 2; b++)
        if (st.clrBank && (st.wrBank == 1'(b))) flag[b] <= '0;
      if (st.wrEn) begin
        mem[st.wrBank][st.wrAddr]  <= inByte;
        flag[st.wrBank][st.wrAddr] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdByte = mem[st.rdBank][st.rdAddr];
    rdOk   = !st.forceIdle && (!st.useFlag || flag[st.rdBank][st.rdAddr]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByte  <= IDLE_BYTE;
      outValid <= 1'b0;
      outStart <= 1'b0;
    end else begin
      outByte  <= (st.live && rdOk) ? rdByte : IDLE_BYTE;
      outValid <= st.live;
      outStart <= st.frameMark;
    end
  end

  // R3: ping-pong banks never collide
  a_r3_bank_split: assert property (@(posedge clk) disable iff (!rstN)
    st.live |-> (st.wrBank != st.rdBank));

  // R9: idle byte whenever no slot is presented
  a_r9_gap_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outByte == IDLE_BYTE));

  // R3: frame mark only on a presented slot
  a_r3_mark_valid: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);
endmodule

// File: rtl/slot_interchanger.sv
module slot_interchanger
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [7:0]       inByte,
  input  logic             modeRandWr,
  input  logic             cfgWe,
  input  logic [IDX_W:0]   cfgIdx,
  input  logic [IDX_W:0]   cfgSel,
  input  logic             cfgBusy,
  output logic [7:0]       outByte,
  output logic             outValid,
  output logic             outStart
);
  strobe_t st;

  tsi_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .modeRandWr(modeRandWr),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgSel(cfgSel), .cfgBusy(cfgBusy), .st(st)
  );

  tsi_datapath #(.SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inByte(inByte),
    .outByte(outByte), .outValid(outValid), .outStart(outStart)
  );
endmodule

// File: tb/sim_slot_interchanger.sv
`timescale 1ns/1ps
module sim_slot_interchanger;
  localparam int NS = 32;

  typedef struct packed {
    logic       mode;
    logic [4:0] mul;
    logic [4:0] add;
    logic [3:0] idleEvery;
    logic [7:0] seed;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{mode:1'b0, mul:5'd1,  add:5'd0,  idleEvery:4'd0, seed:8'h10},
    '{mode:1'b0, mul:5'd5,  add:5'd3,  idleEvery:4'd4, seed:8'h21},
    '{mode:1'b0, mul:5'd31, add:5'd31, idleEvery:4'd0, seed:8'h77},
    '{mode:1'b1, mul:5'd3,  add:5'd7,  idleEvery:4'd0, seed:8'h3C},
    '{mode:1'b1, mul:5'd2,  add:5'd1,  idleEvery:4'd0, seed:8'h90},
    '{mode:1'b1, mul:5'd7,  add:5'd2,  idleEvery:4'd3, seed:8'hC5}
  };

  logic       clk = 1'b0;
  logic       rstN, frameStart, modeRandWr, cfgWe, cfgBusy;
  logic [7:0] inByte;
  logic [5:0] cfgIdx, cfgSel;
  logic [7:0] outByte;
  logic       outValid, outStart;

  always #2.5 clk = ~clk;

  slot_interchanger #(.SLOTS(NS)) u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .inByte(inByte),
    .modeRandWr(modeRandWr), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgSel(cfgSel),
    .cfgBusy(cfgBusy), .outByte(outByte), .outValid(outValid), .outStart(outStart)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  int         bSel [NS];
  bit         bBusy [NS];
  logic [7:0] fIn [NS];
  logic [7:0] prevIn [NS];
  logic [7:0] fOut [NS];
  logic       fValid [NS];
  logic       fStart [NS];
  logic [7:0] expOut [NS];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // caller sits at a negedge; inputs change only at negedges
  task automatic cfgWrite(input int idx, input int sel, input bit busy);
    cfgWe = 1'b1; cfgIdx = 6'(idx); cfgSel = 6'(sel); cfgBusy = busy;
    @(negedge clk);
    cfgWe = 1'b0;
    if (idx < NS && sel < NS) begin
      bSel[idx] = sel;
      bBusy[idx] = busy;
    end
  endtask

  task automatic runFrame(input int cfgAt, input int ci, input int cs, input bit cb);
    for (int s = 0; s < NS; s++) begin
      frameStart = (s == 0);
      inByte = fIn[s];
      cfgWe = (s == cfgAt);
      cfgIdx = 6'(ci); cfgSel = 6'(cs); cfgBusy = cb;
      @(negedge clk);
      fOut[s] = outByte;
      fValid[s] = outValid;
      fStart[s] = outStart;
    end
    frameStart = 1'b0;
    cfgWe = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      frameStart = 1'b0;
      inByte = ~fIn[i % NS];
      @(negedge clk);
      chk("R9 gap valid", outValid, 0);
      chk("R9 gap byte", outByte, 8'hFF);
    end
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int s = 0; s < NS; s++) fIn[s] = 8'(seed + s * 7);
  endtask

  task automatic nextFrame(input logic [7:0] seed);
    for (int s = 0; s < NS; s++) prevIn[s] = fIn[s];
    fill(seed);
  endtask

  task automatic buildExp(input bit m);
    for (int k = 0; k < NS; k++) expOut[k] = 8'hFF;
    if (!m) begin
      for (int k = 0; k < NS; k++) if (bBusy[k]) expOut[k] = prevIn[bSel[k]];
    end else begin
      for (int i = 0; i < NS; i++) if (bBusy[i]) expOut[bSel[i]] = prevIn[i];
    end
  endtask

  task automatic chkTiming();
    for (int k = 0; k < NS; k++) chk("R3 valid", fValid[k], 1);
    chk("R3 start slot0", fStart[0], 1);
    chk("R3 start slot1", fStart[1], 0);
  endtask

  initial begin
    rstN = 1'b0; frameStart = 1'b0; inByte = '0; modeRandWr = 1'b0;
    cfgWe = 1'b0; cfgIdx = '0; cfgSel = '0; cfgBusy = 1'b0;
    for (int k = 0; k < NS; k++) begin bSel[k] = 0; bBusy[k] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1 reset byte", outByte, 8'hFF);
    chk("R1 reset valid", outValid, 0);
    chk("R1 reset start", outStart, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: unprogrammed table gives idle output
    fill(8'h01); runFrame(-1, 0, 0, 0);
    fill(8'h44); runFrame(-1, 0, 0, 0);
    for (int k = 0; k < NS; k++) chk("R1 idle table", fOut[k], 8'hFF);
    chkTiming();

    // table-driven scenarios; gap carries junk (R2) and is checked (R9)
    for (int r = 0; r < 6; r++) begin
      modeRandWr = ROWS[r].mode;
      @(negedge clk);
      for (int k = 0; k < NS; k++) begin
        bit busy = (ROWS[r].idleEvery == 0) ||
                   ((k % ROWS[r].idleEvery) != (ROWS[r].idleEvery - 1));
        cfgWrite(k, (k * ROWS[r].mul + ROWS[r].add) % NS, busy);
      end
      fill(ROWS[r].seed); runFrame(-1, 0, 0, 0);
      gap(3);
      nextFrame(ROWS[r].seed ^ 8'hA5); runFrame(-1, 0, 0, 0);
      buildExp(ROWS[r].mode);
      for (int k = 0; k < NS; k++)
        chk(expOut[k] == 8'hFF ? "R6 idle slot" : (ROWS[r].mode ? "R5 placed" : "R4 picked"),
            fOut[k], expOut[k]);
      chkTiming();
    end

    // R7: mid-frame and strobe-cycle writes are deferred
    modeRandWr = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NS; k++) cfgWrite(k, k, 1'b1);
    fill(8'h05); runFrame(-1, 0, 0, 0);
    nextFrame(8'h61); runFrame(1, 3, 7, 1'b1);
    buildExp(1'b0);
    chk("R7 old entry held", fOut[3], expOut[3]);
    bSel[3] = 7;
    nextFrame(8'hB2); runFrame(0, 10, 10, 1'b0);
    buildExp(1'b0);
    chk("R7 new entry used", fOut[3], expOut[3]);
    chk("R7 strobe write deferred", fOut[10], expOut[10]);
    bBusy[10] = 1'b0;
    nextFrame(8'hE3); runFrame(-1, 0, 0, 0);
    buildExp(1'b0);
    chk("R6 idle after update", fOut[10], 8'hFF);
    chk("R7 remap persists", fOut[3], expOut[3]);

    // R8: out-of-range writes are dropped
    cfgWrite(63, 0, 1'b0);
    cfgWrite(5, 40, 1'b0);
    cfgWrite(33, 1, 1'b0);
    fill(8'h1F); runFrame(-1, 0, 0, 0);
    nextFrame(8'h8D); runFrame(-1, 0, 0, 0);
    buildExp(1'b0);
    chk("R8 idx 63 ignored", fOut[31], expOut[31]);
    chk("R8 sel 40 ignored", fOut[5], expOut[5]);
    chk("R8 idx 33 ignored", fOut[1], expOut[1]);

    // R2: bytes after the last slot do not overwrite the frame
    fill(8'h33); runFrame(-1, 0, 0, 0);
    gap(NS + 4);
    nextFrame(8'h99); runFrame(-1, 0, 0, 0);
    buildExp(1'b0);
    for (int k = 0; k < NS; k++) chk("R2 overrun ignored", fOut[k], expOut[k]);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule